// File: doc/BRIEF.md
# Bit-Layer Ternary Accumulator

This block forms a dot product without any multiplier. The weights are given as ternary digits (-1, 0, +1), one bit layer at a time, beginning with the least significant layer. For each nonzero digit in the current layer, the controller presents the matching operand for one cycle with a valid strobe. It also sets a subtract flag when the digit is -1. The block then adds or subtracts the sign-extended operand into a narrow accumulator. A layer-end strobe closes the layer: the accumulator shifts right arithmetically by one, and the bit that leaves it is already a final result bit, so it is emitted serially with a strobe.

After the configured number of layers, a one-cycle done pulse marks completion. At that point the accumulator holds the upper part of the result, and the serial bits collected earlier form the lower part. The full signed result is `{acc_hi_o, serial bits}`, with the first serial bit as bit 0. From then on the block ignores operands and layer ends until a synchronous clear starts a new product.

Weight decoding, operand fetch and storage belong to the surrounding logic.

Top module: `bit_layer_acc`

## Requirements
- R1: After reset, or in the cycle after `clr_i` is high, `acc_hi_o` is 0 and `bit_vld_o` and `done_o` are 0. A clear wins over an operand or layer end presented in the same cycle.
- R2: When `op_vld_i` is high, the signed operand `op_i` is sign-extended and added to the accumulator (`op_neg_i`=0) or subtracted from it (`op_neg_i`=1). The new value appears on `acc_hi_o` one cycle later. With no strobe, the accumulator holds.
- R3: When `layer_end_i` is high, `bit_o` in the next cycle equals bit 0 of the accumulator before the shift, and `bit_vld_o` is high for that one cycle. The accumulator becomes its arithmetic right shift by one. `layer_end_i` and `op_vld_i` must never be high together.
- R4: A layer with no nonzero digits costs exactly one cycle, the layer end, and changes the result only through its shift.
- R5: After exactly N_LAYER accepted layer ends, `done_o` is high for one cycle, in the same cycle as the last serial bit. The concatenation of `acc_hi_o` and the N_LAYER serial bits (first bit lowest) equals the two's-complement dot product sum(operand x weight), where weight = sum(digit x 2^layer).
- R6: Negating every digit of every weight takes the same number of cycles and yields the negated result.
- R7: Once N_LAYER layers are done, `op_vld_i` and `layer_end_i` have no effect: `acc_hi_o` stays unchanged and `bit_vld_o` and `done_o` stay low until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of accumulator and layer count |
| op_vld_i | input | 1 | Operand strobe: apply `op_i` this cycle |
| op_neg_i | input | 1 | 1 subtracts the operand, 0 adds it |
| op_i | input | OP_W | Signed operand |
| layer_end_i | input | 1 | Ends the current bit layer; shifts right by one |
| bit_o | output | 1 | Finished result bit retired by the last shift |
| bit_vld_o | output | 1 | `bit_o` is valid this cycle |
| acc_hi_o | output | OP_W+clog2(N_OPS)+1 | Accumulator, upper result part once done |
| done_o | output | 1 | One-cycle pulse after the last layer |

## Verification
A clear can land in the same cycle as an operand strobe or a layer end. The bench loads a nonzero accumulator, then drives a clear together with an add, and later together with a shift. It judges the result at the ports: `acc_hi_o` must read zero and `bit_vld_o` must stay low. Random products with random ternary digit layers, including the negated-weight mirror and empty layers, are compared against a dot product computed independently in the bench.

// File: rtl/blta_pkg.sv
package blta_pkg;

  typedef enum logic [2:0] {
    CMD_HOLD  = 3'd0,
    CMD_ADD   = 3'd1,
    CMD_SUB   = 3'd2,
    CMD_SHIFT = 3'd3,
    CMD_CLEAR = 3'd4
  } acc_cmd_e;

  function automatic int acc_width(input int op_w, input int n_ops);
    return op_w + $clog2(n_ops) + 1;
  endfunction

endpackage

// File: rtl/blta_rst_sync.sv
module blta_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/blta_cmd_dec.sv
module blta_cmd_dec
  import blta_pkg::*;
(
  input  logic     clr_i,
  input  logic     op_vld_i,
  input  logic     op_neg_i,
  input  logic     layer_end_i,
  input  logic     fin_i,
  output acc_cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_HOLD;
    if (clr_i) begin
      cmd_o = CMD_CLEAR;
    end else if (!fin_i) begin
      if (layer_end_i)   cmd_o = CMD_SHIFT;
      else if (op_vld_i) cmd_o = op_neg_i ? CMD_SUB : CMD_ADD;
    end
  end
endmodule

// File: rtl/blta_acc_dp.sv
module blta_acc_dp
  import blta_pkg::*;
#(
  parameter int OP_W      = 9,
  parameter int ACC_W     = 16,
  parameter bit OP_SIGNED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_cmd_e         cmd_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             bit_o,
  output logic             bit_vld_o
);
  localparam int EXT_W = ACC_W - OP_W;

  logic [ACC_W-1:0] op_ext;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             bit_q, bit_d;
  logic             vld_q, vld_d;
  logic             acc_en;

  generate
    if (OP_SIGNED) begin : g_sext
      assign op_ext = {{EXT_W{op_i[OP_W-1]}}, op_i};
    end else begin : g_zext
      assign op_ext = {{EXT_W{1'b0}}, op_i};
    end
  endgenerate

  always_comb begin
    acc_d  = acc_q;
    bit_d  = bit_q;
    vld_d  = 1'b0;
    acc_en = 1'b1;
    unique case (cmd_i)
      CMD_CLEAR: begin
        acc_d = '0;
        bit_d = 1'b0;
      end
      CMD_ADD:   acc_d = acc_q + op_ext;
      CMD_SUB:   acc_d = acc_q - op_ext;
      CMD_SHIFT: begin
        acc_d = {acc_q[ACC_W-1], acc_q[ACC_W-1:1]};
        bit_d = acc_q[0];
        vld_d = 1'b1;
      end
      default:   acc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (acc_en) begin
        acc_q <= acc_d;
        bit_q <= bit_d;
      end
    end
  end

  assign acc_o     = acc_q;
  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;

  assert_clear_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_CLEAR) |=> (acc_o == '0 && !bit_vld_o));

  assert_shift_arith_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_SHIFT) |=> ($signed(acc_o) == ($signed($past(acc_o)) >>> 1)
                              && bit_o == $past(acc_o[0]) && bit_vld_o));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_HOLD) |=> ($stable(acc_o) && !bit_vld_o));
endmodule

// File: rtl/blta_layer_ctr.sv
module blta_layer_ctr
  import blta_pkg::*;
#(
  parameter int N_LAYER = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  acc_cmd_e cmd_i,
  output logic     fin_o,
  output logic     done_o
);
  localparam int CNT_W = $clog2(N_LAYER + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_LAYER - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(N_LAYER);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = 1'b0;
    cnt_en = 1'b0;
    if (cmd_i == CMD_CLEAR) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (cmd_i == CMD_SHIFT) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
      done_d = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign fin_o  = (cnt_q == FULL);
  assign done_o = done_q;

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_at_fin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fin_o);
endmodule

// File: rtl/bit_layer_acc.sv
module bit_layer_acc
  import blta_pkg::*;
#(
  parameter int OP_W      = 9,
  parameter int N_LAYER   = 16,
  parameter int N_OPS     = 64,
  parameter bit OP_SIGNED = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           op_vld_i,
  input  logic                           op_neg_i,
  input  logic [OP_W-1:0]                op_i,
  input  logic                           layer_end_i,
  output logic                           bit_o,
  output logic                           bit_vld_o,
  output logic [OP_W+$clog2(N_OPS):0]    acc_hi_o,
  output logic                           done_o
);
  localparam int ACC_W = acc_width(OP_W, N_OPS);

  logic     rst_sync_n;
  logic     fin;
  acc_cmd_e cmd;

  blta_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  blta_cmd_dec u_dec (
    .clr_i       (clr_i),
    .op_vld_i    (op_vld_i),
    .op_neg_i    (op_neg_i),
    .layer_end_i (layer_end_i),
    .fin_i       (fin),
    .cmd_o       (cmd)
  );

  blta_acc_dp #(
    .OP_W      (OP_W),
    .ACC_W     (ACC_W),
    .OP_SIGNED (OP_SIGNED)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .cmd_i     (cmd),
    .op_i      (op_i),
    .acc_o     (acc_hi_o),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o)
  );

  blta_layer_ctr #(
    .N_LAYER (N_LAYER)
  ) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .cmd_i  (cmd),
    .fin_o  (fin),
    .done_o (done_o)
  );

  assert_no_add_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(op_vld_i && layer_end_i));

  assert_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (fin && !clr_i) |=> ($stable(acc_hi_o) && !bit_vld_o && !done_o));

  assert_clear_wins_R1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    clr_i |=> (acc_hi_o == '0 && !done_o));
endmodule

// File: tb/tb_bit_layer_acc.sv
module tb_bit_layer_acc;
  localparam int OP_W = 9;
  localparam int NL   = 16;
  localparam int NOPS = 64;
  localparam int ACCW = OP_W + $clog2(NOPS) + 1;
  localparam int MAXK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, vld = 1'b0, neg = 1'b0, lend = 1'b0;
  logic [OP_W-1:0] op = '0;
  logic bit_o, bit_vld, done;
  logic [ACCW-1:0] acc_hi;

  int n_run = 0, n_fail = 0;
  int ops [MAXK];
  int dig [MAXK][NL];

  always #4 clk = ~clk;

  bit_layer_acc #(.OP_W(OP_W), .N_LAYER(NL), .N_OPS(NOPS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .op_vld_i(vld), .op_neg_i(neg),
    .op_i(op), .layer_end_i(lend), .bit_o(bit_o), .bit_vld_o(bit_vld),
    .acc_hi_o(acc_hi), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic v, input logic n, input int o, input logic e);
    clr = c; vld = v; neg = n; op = OP_W'(o); lend = e;
    @(negedge clk);
  endtask

  function automatic longint exp_dot(input int nk, input bit flip);
    longint s = 0;
    for (int k = 0; k < nk; k++) begin
      longint w = 0;
      for (int l = 0; l < NL; l++) w += longint'(flip ? -dig[k][l] : dig[k][l]) <<< l;
      s += longint'(ops[k]) * w;
    end
    return s;
  endfunction

  task automatic run_dot(input int nk, input bit flip, output logic [ACCW+NL-1:0] res,
                         output int cycles, output bit done_ok);
    logic [NL-1:0] bits = '0;
    cycles = 0; done_ok = 1'b1;
    cyc(1, 0, 0, 0, 0);
    for (int l = 0; l < NL; l++) begin
      for (int k = 0; k < nk; k++) begin
        int d = flip ? -dig[k][l] : dig[k][l];
        if (d != 0) begin
          cyc(0, 1, d < 0, ops[k], 0);
          cycles++;
          if (done || bit_vld) done_ok = 1'b0;
        end
      end
      cyc(0, 0, 0, 0, 1);
      cycles++;
      bits[l] = bit_o;
      if (!bit_vld || done != (l == NL - 1)) done_ok = 1'b0;
    end
    cyc(0, 0, 0, 0, 0);
    if (done) done_ok = 1'b0;
    res = {acc_hi, bits};
  endtask

  task automatic rand_weights(input int nk, input int density);
    for (int k = 0; k < nk; k++) begin
      ops[k] = int'($urandom_range(0, 511)) - 256;
      for (int l = 0; l < NL; l++) begin
        int r = int'($urandom_range(0, 99));
        dig[k][l] = (r >= density) ? 0 : (($urandom_range(0, 1) == 1) ? 1 : -1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [ACCW+NL-1:0] r1, r2;
    int c1, c2, nz;
    bit d1, d2;
    logic [ACCW+NL-1:0] e;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(acc_hi == '0 && !bit_vld && !done, "R1 reset", acc_hi, 0);

    // R2 add, subtract, hold
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 5, 0);
    chk($signed(acc_hi) == 5, "R2 add", $signed(acc_hi), 5);
    cyc(0, 1, 1, 7, 0);
    chk($signed(acc_hi) == -2, "R2 sub", $signed(acc_hi), -2);
    cyc(0, 1, 1, -256, 0);
    chk($signed(acc_hi) == 254, "R2 sub negative", $signed(acc_hi), 254);
    cyc(0, 0, 1, 99, 0);
    chk($signed(acc_hi) == 254, "R2 hold", $signed(acc_hi), 254);

    // R1 clear wins over add
    cyc(1, 1, 0, 100, 0);
    chk(acc_hi == '0, "R1 clear+add", acc_hi, 0);

    // R3 shift of -3
    cyc(0, 1, 1, 3, 0);
    cyc(0, 0, 0, 0, 1);
    chk(bit_vld && bit_o == 1'b1 && $signed(acc_hi) == -2, "R3 shift1", $signed(acc_hi), -2);
    cyc(0, 0, 0, 0, 1);
    chk(bit_vld && bit_o == 1'b0 && $signed(acc_hi) == -1, "R3 shift2", $signed(acc_hi), -1);
    cyc(0, 0, 0, 0, 0);
    chk(!bit_vld, "R3 strobe one cycle", bit_vld, 0);

    // R1 clear wins over shift
    cyc(1, 0, 0, 0, 1);
    chk(acc_hi == '0 && !bit_vld, "R1 clear+shift", bit_vld, 0);

    // R4 all layers empty
    for (int k = 0; k < MAXK; k++) begin
      ops[k] = 77;
      for (int l = 0; l < NL; l++) dig[k][l] = 0;
    end
    run_dot(MAXK, 0, r1, c1, d1);
    chk(r1 == '0, "R4 empty result", r1, 0);
    chk(c1 == NL, "R4 empty cycles", c1, NL);

    // R5 extreme: all +1 digits with most negative operand
    for (int k = 0; k < MAXK; k++) begin
      ops[k] = -256;
      for (int l = 0; l < NL; l++) dig[k][l] = 1;
    end
    run_dot(MAXK, 0, r1, c1, d1);
    e = (ACCW+NL)'(exp_dot(MAXK, 0));
    chk(r1 == e, "R5 extreme", $signed(r1), $signed(e));
    chk(d1, "R5 done timing extreme", d1, 1);

    // R7 ignored after done
    r2 = {acc_hi, 16'h0};
    cyc(0, 1, 0, 123, 0);
    cyc(0, 0, 0, 0, 1);
    chk(acc_hi == r2[ACCW+NL-1:NL] && !bit_vld && !done, "R7 frozen", acc_hi, r2[ACCW+NL-1:NL]);

    // R5, R6 random products
    for (int t = 0; t < 30; t++) begin
      nz = 1 + int'($urandom_range(0, MAXK - 1));
      rand_weights(nz, (t % 3 == 0) ? 15 : 40);
      run_dot(nz, 0, r1, c1, d1);
      e = (ACCW+NL)'(exp_dot(nz, 0));
      chk(r1 == e, "R5 random dot", $signed(r1), $signed(e));
      chk(d1, "R5 done/bit timing", d1, 1);
      run_dot(nz, 1, r2, c2, d2);
      chk(r2 == -r1, "R6 negated result", $signed(r2), -$signed(r1));
      chk(c2 == c1, "R6 same cycles", c2, c1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule